// File: doc/BRIEF.md
# SDRAM Special-Mode Command Override

This block sits between a memory cycle requester and the command pins of an SDRAM device. A small 8-bit control register selects what happens to each requested cycle. In normal operation a request goes out as a plain read or write command carrying its row address. When a special mode is selected, the request is rewritten into a fixed initialization command instead: NOP, precharge-all, mode-register-set or CBR refresh. Firmware brings the memory up by stepping through these modes and issuing one dummy access in each.

In mode-register-set, the requester's own address lines supply the command: the low seven bits of the row address become burst length, wrap type and CAS latency on the memory address bus, and the upper bits are driven low. Forced precharge, MRS and CBR commands are held back until at least one NOP-mode cycle has gone out since reset. A blocked request still completes its handshake, but the bus stays deselected.

The same register gates an interval counter that raises auto-refresh requests while refresh is enabled and the block is in normal command mode. A pending auto-refresh wins over a request that arrives at the same time.

Top module: `sdram_cmd_override`

## Requirements
- R1: After reset the register reads 0x08, the command bus is deselected (CS#=1) with MA=0, and `cyc_ack` is low.
- R2: A register write stores bits 4:0 (bits 4:3 = refresh control, bits 2:0 = mode code). Bits 7:5 always read as zero, and reserved codes written to either field are stored and read back unchanged.
- R3: In mode 000, a request sampled at an idle clock edge drives a command one cycle after that edge. A read (`cyc_we`=0) drives CS#/RAS#/CAS#/WE# = 0101 and a write drives 0100, with MA equal to `cyc_row`.
- R4: Every accepted request raises `cyc_ack` for exactly one cycle, one clock after its command. The bus is deselected while `cyc_ack` is high.
- R5: In mode 001, a request drives NOP (0111) with MA=0.
- R6: In mode 010, once initialized, a request drives precharge-all (0010) with MA=0x400 (MA[10]=1).
- R7: In mode 011, once initialized, a request drives MRS (0000). MA[6:0] equals `cyc_row[6:0]` and MA[11:7] is zero.
- R8: In mode 100, once initialized, a request drives CBR refresh (0001) with MA=0.
- R9: Until a NOP-mode request has been accepted after reset, requests in modes 010, 011 and 100 drive deselect (1111) and are still acknowledged on the R4 schedule.
- R10: Mode codes 101, 110 and 111 produce the same commands as mode 000.
- R11: With refresh control 01 and an effective normal mode, an auto-refresh CBR (0001, MA=0) appears REF_PERIOD+1 clocks after the enabling write edge and then every REF_PERIOD clocks. It is not acknowledged.
- R12: No auto-refresh CBR appears while refresh control is 00, 10 or 11, or while a special mode (001 to 100) is selected.
- R13: When an auto-refresh is pending and a request is sampled at the same idle edge, the CBR goes out first, the bus is deselected for one cycle, and the request's command follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cyc_req | input | 1 | Cycle request, held until acknowledged |
| cyc_we | input | 1 | Cycle direction, 1 = write |
| cyc_row | input | 12 | Row address of the requested cycle |
| cyc_ack | output | 1 | One-cycle acknowledge |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ma | output | 12 | SDRAM memory address |

## Verification
A register write takes effect at the write edge. A request command is due one cycle after the edge that samples the request, and its acknowledge one cycle after that. An auto-refresh CBR is due REF_PERIOD+1 edges after the enabling write, or after the previous refresh boundary. The bench drives every input at a falling edge and counts rising edges with its own counter. It samples at the falling edge that follows the edge on which each result is due, so each expected value is compared at a known edge number.

// File: rtl/sdram_ovr_pkg.sv
package sdram_ovr_pkg;

  localparam int MA_W  = 12;
  localparam int REG_W = 8;

  // Writable bits of the control byte; the rest always read zero.
  localparam logic [REG_W-1:0] CFG_WMASK = 8'h1F;
  localparam logic [REG_W-1:0] CFG_RESET = 8'h08;

  localparam logic [1:0] REF_ON = 2'b01;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = 4'b1111;
  localparam sd_cmd_t CMD_NOP   = 4'b0111;
  localparam sd_cmd_t CMD_PALL  = 4'b0010;
  localparam sd_cmd_t CMD_MRS   = 4'b0000;
  localparam sd_cmd_t CMD_CBR   = 4'b0001;
  localparam sd_cmd_t CMD_READ  = 4'b0101;
  localparam sd_cmd_t CMD_WRITE = 4'b0100;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_MRS    = 3'd3,
    MODE_CBR    = 3'd4
  } ovr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_ACK,
    ST_REF
  } ovr_state_e;

  // Reserved codes fall back to normal command generation.
  function automatic ovr_mode_e eff_mode(input logic [2:0] code);
    if (code > 3'd4) return MODE_NORMAL;
    return ovr_mode_e'(code);
  endfunction

  // Forced commands that require a prior NOP.
  function automatic logic needs_init(input ovr_mode_e m);
    return (m == MODE_PALL) || (m == MODE_MRS) || (m == MODE_CBR);
  endfunction

  // MRS word: low 7 row bits carry burst length, wrap and latency.
  function automatic logic [MA_W-1:0] mrs_word(input logic [MA_W-1:0] row);
    return {{(MA_W-7){1'b0}}, row[6:0]};
  endfunction

  function automatic sd_cmd_t mode_cmd(input ovr_mode_e m, input logic we);
    case (m)
      MODE_NOP:  return CMD_NOP;
      MODE_PALL: return CMD_PALL;
      MODE_MRS:  return CMD_MRS;
      MODE_CBR:  return CMD_CBR;
      default:   return we ? CMD_WRITE : CMD_READ;
    endcase
  endfunction

  function automatic logic [MA_W-1:0] mode_addr(input ovr_mode_e m,
                                                input logic [MA_W-1:0] row);
    logic [MA_W-1:0] a;
    case (m)
      MODE_NOP:  a = '0;
      MODE_PALL: begin a = '0; a[10] = 1'b1; end
      MODE_MRS:  a = mrs_word(row);
      MODE_CBR:  a = '0;
      default:   a = row;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sdram_ovr_cfg_reg.sv
module sdram_ovr_cfg_reg
  import sdram_ovr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [2:0]       mode_code,
  output logic [1:0]       ref_code
);

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_RESET;
    else if (wr) cfg_q <= wdata & CFG_WMASK;
  end

  assign rdata     = cfg_q;
  assign mode_code = cfg_q[2:0];
  assign ref_code  = cfg_q[4:3];

endmodule

// File: rtl/sdram_ovr_refresh_timer.sv
module sdram_ovr_refresh_timer #(
  parameter int REF_PERIOD = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic grant,
  output logic pending
);

  localparam int CNT_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             wrap;

  assign wrap = enable && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!enable || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (!enable) begin
      pend_q <= 1'b0;
    end else if (wrap) begin
      pend_q <= 1'b1;
    end else if (grant) begin
      pend_q <= 1'b0;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/sdram_ovr_cmd_gen.sv
module sdram_ovr_cmd_gen
  import sdram_ovr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_code,
  input  logic            ref_enable,
  input  logic            ref_pending,
  input  logic            req,
  input  logic            we,
  input  logic [MA_W-1:0] row,
  output logic            ref_grant,
  output logic            req_issue,
  output logic            init_done,
  output logic            ack,
  output sd_cmd_t         cmd,
  output logic [MA_W-1:0] ma
);

  ovr_state_e      st_q, st_d;
  sd_cmd_t         cmd_q, cmd_d;
  logic [MA_W-1:0] ma_q, ma_d;
  logic            init_q;
  ovr_mode_e       mode;
  logic            blocked;

  assign mode      = eff_mode(mode_code);
  assign blocked   = needs_init(mode) && !init_q;
  assign ref_grant = (st_q == ST_IDLE) && ref_pending && ref_enable;
  assign req_issue = (st_q == ST_IDLE) && req && !ref_grant;

  always_comb begin
    st_d  = st_q;
    cmd_d = CMD_DESEL;
    ma_d  = '0;
    case (st_q)
      ST_IDLE: begin
        if (ref_grant) begin
          st_d  = ST_REF;
          cmd_d = CMD_CBR;
        end else if (req_issue) begin
          st_d = ST_CMD;
          if (!blocked) begin
            cmd_d = mode_cmd(mode, we);
            ma_d  = mode_addr(mode, row);
          end
        end
      end
      ST_CMD:  st_d = ST_ACK;
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_DESEL;
      ma_q   <= '0;
      init_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      ma_q  <= ma_d;
      if (req_issue && (mode == MODE_NOP)) init_q <= 1'b1;
    end
  end

  assign ack       = (st_q == ST_ACK);
  assign cmd       = cmd_q;
  assign ma        = ma_q;
  assign init_done = init_q;

endmodule

// File: rtl/sdram_cmd_override.sv
module sdram_cmd_override
  import sdram_ovr_pkg::*;
#(
  parameter int REF_PERIOD = 780
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        cyc_req,
  input  logic        cyc_we,
  input  logic [11:0] cyc_row,
  output logic        cyc_ack,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [11:0] sd_ma
);

  logic [2:0] mode_code;
  logic [1:0] ref_code;
  logic       ref_on;
  logic       ref_pending;
  logic       ref_grant;
  logic       req_issue;
  logic       nop_seen;
  sd_cmd_t    cmd;

  sdram_ovr_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .mode_code (mode_code),
    .ref_code  (ref_code)
  );

  assign ref_on = (ref_code == REF_ON) && (eff_mode(mode_code) == MODE_NORMAL);

  sdram_ovr_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (ref_on),
    .grant   (ref_grant),
    .pending (ref_pending)
  );

  sdram_ovr_cmd_gen u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_code   (mode_code),
    .ref_enable  (ref_on),
    .ref_pending (ref_pending),
    .req         (cyc_req),
    .we          (cyc_we),
    .row         (cyc_row),
    .ref_grant   (ref_grant),
    .req_issue   (req_issue),
    .init_done   (nop_seen),
    .ack         (cyc_ack),
    .cmd         (cmd),
    .ma          (sd_ma)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdram_ovr_chk.sv
module sdram_ovr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_issue,
  input logic        ref_on,
  input logic        nop_seen,
  input logic        cyc_ack,
  input logic        sd_cs_n,
  input logic        sd_ras_n,
  input logic        sd_cas_n,
  input logic        sd_we_n,
  input logic [11:0] sd_ma
);

  logic [3:0] bus;
  assign bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R4
  ack_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_issue |=> ##1 cyc_ack);

  // R4
  ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ack |-> $past(req_issue, 2));

  // R4
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ack |=> !cyc_ack);

  // R4
  desel_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ack |-> sd_cs_n);

  // R7
  mrs_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0000) |-> (sd_ma[11:7] == 5'd0));

  // R9
  init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus == 4'b0010) || (bus == 4'b0000)) |-> nop_seen);

  // R11
  auto_ref_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus == 4'b0001) && !$past(req_issue)) |-> $past(ref_on));

endmodule

bind sdram_cmd_override sdram_ovr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_issue (req_issue),
  .ref_on    (ref_on),
  .nop_seen  (nop_seen),
  .cyc_ack   (cyc_ack),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_ma     (sd_ma)
);

// File: tb/test_sdram_cmd_override.sv
module test_sdram_cmd_override;

  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cyc_req = 1'b0;
  logic        cyc_we = 1'b0;
  logic [11:0] cyc_row = '0;
  logic        cyc_ack;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_ma;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit done   = 1'b0;

  sdram_cmd_override #(.REF_PERIOD(P)) i_sdram_cmd_override (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cyc_req(cyc_req), .cyc_we(cyc_we),
    .cyc_row(cyc_row), .cyc_ack(cyc_ack), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ma(sd_ma)
  );

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  function automatic logic [3:0] bus();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v, output int wedge);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(posedge clk); #1 wedge = edges;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] v);
    int w;
    wr_reg(v, w);
  endtask

  // Issue one request and check its command, address and ack timing.
  task automatic run_cycle(input string tag, input logic we, input logic [11:0] row,
                           input logic [3:0] exp_cmd, input logic [11:0] exp_ma);
    @(negedge clk); cyc_req = 1'b1; cyc_we = we; cyc_row = row;
    @(posedge clk); @(negedge clk);
    check({tag, " cmd"}, bus(), exp_cmd);
    check({tag, " ma"}, sd_ma, exp_ma);
    check("R4 no early ack", cyc_ack, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R4 ack due", cyc_ack, 1'b1);
    check("R4 desel on ack", bus(), 4'hF);
    cyc_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R4 ack one cycle", cyc_ack, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reg reset", reg_rdata, 8'h08);
    check("R1 bus desel", bus(), 4'hF);
    check("R1 ma zero", sd_ma, 12'h000);
    check("R1 ack low", cyc_ack, 1'b0);
  endtask

  task automatic t_reg();
    set_reg(8'h00); check("R2 write 00", reg_rdata, 8'h00);
    set_reg(8'hFF); check("R2 reserved bits zero", reg_rdata, 8'h1F);
    set_reg(8'hF5); check("R2 reserved codes kept", reg_rdata, 8'h15);
    set_reg(8'h00);
  endtask

  task automatic t_normal();
    run_cycle("R3 read", 1'b0, 12'h5A3, 4'b0101, 12'h5A3);
    run_cycle("R3 write", 1'b1, 12'h0FF, 4'b0100, 12'h0FF);
  endtask

  task automatic t_gate();
    set_reg(8'h02); run_cycle("R9 pall blocked", 1'b0, 12'h123, 4'hF, 12'h000);
    set_reg(8'h03); run_cycle("R9 mrs blocked", 1'b0, 12'h0B2, 4'hF, 12'h000);
    set_reg(8'h04); run_cycle("R9 cbr blocked", 1'b0, 12'h000, 4'hF, 12'h000);
  endtask

  task automatic t_forced();
    set_reg(8'h01); run_cycle("R5 nop", 1'b1, 12'hABC, 4'b0111, 12'h000);
    set_reg(8'h02); run_cycle("R6 pall", 1'b0, 12'h123, 4'b0010, 12'h400);
    set_reg(8'h03); run_cycle("R7 mrs", 1'b0, 12'hFB2, 4'b0000, 12'h032);
    run_cycle("R7 mrs alt", 1'b1, 12'h04D, 4'b0000, 12'h04D);
    set_reg(8'h04); run_cycle("R8 cbr", 1'b0, 12'h777, 4'b0001, 12'h000);
  endtask

  task automatic t_reserved();
    set_reg(8'h05); check("R10 stored", reg_rdata, 8'h05);
    run_cycle("R10 code5 write", 1'b1, 12'h321, 4'b0100, 12'h321);
    set_reg(8'h07);
    run_cycle("R10 code7 read", 1'b0, 12'h9E0, 4'b0101, 12'h9E0);
    set_reg(8'h00);
  endtask

  task automatic t_refresh();
    int w;
    int early;
    int seen;
    early = 0;
    wr_reg(8'h08, w);
    // Wait until the negedge after edge w+P with no CBR.
    while (edges < w + P) begin
      @(posedge clk); @(negedge clk);
      if (bus() == 4'b0001) early++;
    end
    check("R11 no early cbr", early, 0);
    cyc_req = 1'b1; cyc_we = 1'b0; cyc_row = 12'h2C4;
    @(posedge clk); @(negedge clk);
    check("R11 cbr due", bus(), 4'b0001);
    check("R11 cbr ma", sd_ma, 12'h000);
    check("R11 cbr no ack", cyc_ack, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R13 gap desel", bus(), 4'hF);
    @(posedge clk); @(negedge clk);
    check("R13 request after cbr", bus(), 4'b0101);
    check("R13 request ma", sd_ma, 12'h2C4);
    @(posedge clk); @(negedge clk);
    check("R13 ack", cyc_ack, 1'b1);
    cyc_req = 1'b0;
    seen = 0;
    while (seen == 0 && edges < w + 3 * P) begin
      @(posedge clk); @(negedge clk);
      if (bus() == 4'b0001) seen = edges;
    end
    check("R11 period", seen, w + 2 * P + 1);
  endtask

  task automatic t_no_refresh(input string tag, input logic [7:0] v);
    int cnt;
    cnt = 0;
    set_reg(v);
    repeat (3 * P) begin
      @(posedge clk); @(negedge clk);
      if (bus() == 4'b0001) cnt++;
    end
    check(tag, cnt, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    set_reg(8'h00);
    t_reg();
    t_normal();
    t_gate();
    t_forced();
    t_reserved();
    t_refresh();
    t_no_refresh("R12 refresh off", 8'h00);
    t_no_refresh("R12 special mode", 8'h09);
    t_no_refresh("R12 reserved refresh", 8'h10);
    t_no_refresh("R12 reserved refresh 11", 8'h18);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule